// File: doc/BRIEF.md
# Reconfigurable Booth Multiplier Tile

This block is a hard multiplier tile meant to sit among the logic of a programmable fabric. It multiplies two operand words and returns a product twice as wide. A static mode input selects one of two arithmetic modes. In the first, both operands are two's complement. In the second, both operands are unsigned and one bit narrower. Both modes run through the same array. For unsigned work, each operand is conditioned to a non-negative value of the full width, so the signed array gives the correct unsigned result.

Partial products come from radix-4 modified Booth recoding of operand `b`. A tree of 3:2 compressors reduces them to a sum row and a carry row. A parallel-prefix carry-lookahead adder adds these two rows to form the product. Two static timing inputs choose how the product appears: combinationally, registered once at the output, or in a two-stage pipeline. In the pipeline, one register bank sits after the reduction tree and a second sits after the adder. Clock enable and synchronous reset act on every register.

Top module: `booth_mult_tile`

## Requirements
- R1: With `cfg_unsigned`=0, `a` and `b` are read as 18-bit two's complement and `p` is their exact 36-bit two's complement product.
- R2: With `cfg_unsigned`=1, bit 17 of each operand is ignored. The low 17 bits are multiplied as unsigned numbers, so `p[35:34]` is always 00.
- R3: With `cfg_pipe`=0 and `cfg_sync`=0, `p` follows `a`, `b` and `cfg_unsigned` combinationally in the same cycle.
- R4: With `cfg_pipe`=0 and `cfg_sync`=1, `p` shows the product of the operands and mode present at the previous rising edge where `ce`=1. This gives one cycle of latency.
- R5: With `cfg_pipe`=1, whatever the value of `cfg_sync`, a new operand pair can be accepted every enabled cycle. Each product appears two enabled edges after its operands.
- R6: While `ce`=0, every register holds its value, so in the registered and pipelined timings `p` does not change even when the operands change.
- R7: `rst`=1 at a rising edge clears all registers to zero whatever the value of `ce`, so a registered or pipelined `p` reads 0 after that edge.
- R8: The extreme products are exact. Signed -131072×-131072 gives 0x400000000. Signed 131071×131071 gives 0x3FFFC0001. Signed -131072×131071 gives 0xC00020000. Unsigned 0x3FFFF×0x3FFFF gives 0x3FFFC0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers, active high |
| cfg_unsigned | input | 1 | 1 = unsigned narrow mode, 0 = signed full width |
| cfg_sync | input | 1 | 1 = registered product (used when cfg_pipe is 0) |
| cfg_pipe | input | 1 | 1 = two-stage pipelined product |
| a | input | OP_W (18) | Multiplicand |
| b | input | OP_W (18) | Multiplier, Booth recoded |
| p | output | 2*OP_W (36) | Product |

## Verification
In combinational timing, a product is due in the same cycle as its operands. The bench samples it 1 ns after driving, before the next edge. In registered timing, the result appears one enabled edge after the operands, and in pipelined timing two. The bench streams a new vector at every falling edge and compares each falling edge against the vector driven one or two falls earlier, so a latency that is off by one edge shows up as a mismatch. Hold and reset are checked at the falling edges around the edges where they act. The checker tests the same latencies with `$past` of depth one and two.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

  // One radix-4 Booth digit: sign and magnitude select (0, 1 or 2).
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  typedef enum logic [1:0] {
    TM_COMB = 2'd0,
    TM_REG  = 2'd1,
    TM_PIPE = 2'd2
  } timing_t;

  // Recode the bit triple {b[2i+1], b[2i], b[2i-1]} into a digit.
  function automatic booth_dig_t booth_encode(input logic [2:0] trip);
    booth_dig_t d;
    d.neg = trip[2];
    d.one = trip[1] ^ trip[0];
    d.two = (trip == 3'b100) || (trip == 3'b011);
    return d;
  endfunction

  // Decode the static timing inputs; the pipeline setting dominates.
  function automatic timing_t timing_select(input logic sync_bit, input logic pipe_bit);
    if (pipe_bit)      return TM_PIPE;
    else if (sync_bit) return TM_REG;
    else               return TM_COMB;
  endfunction

  // Number of rows left after one layer of 3:2 compression.
  function automatic int rows_after_layer(input int n);
    return n - (n / 3);
  endfunction

endpackage

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_mult_pkg::*;
#(
  parameter int OP_W = 18
) (
  input  logic [OP_W-1:0]   a_x,
  input  logic [OP_W-1:0]   b_x,
  output logic [2*OP_W-1:0] rows [OP_W/2+1]
);
  localparam int PW  = 2 * OP_W;
  localparam int NPP = OP_W / 2;

  logic [OP_W:0]   b_pad;
  logic [PW-1:0]   a_se;
  logic [PW-1:0]   neg_row;

  assign b_pad = {b_x, 1'b0};
  assign a_se  = {{OP_W{a_x[OP_W-1]}}, a_x};
  assign neg_row[PW-1:OP_W] = '0;

  for (genvar i = 0; i < NPP; i++) begin : g_digit
    booth_dig_t  dig;
    logic [PW-1:0] mag;
    assign dig = booth_encode(b_pad[2*i+2:2*i]);
    assign mag = dig.one ? a_se : (dig.two ? (a_se << 1) : '0);
    // One's complement here; the +1 lives in the correction row.
    assign rows[i] = (dig.neg ? ~mag : mag) << (2 * i);
    assign neg_row[2*i]   = dig.neg;
    assign neg_row[2*i+1] = 1'b0;
  end

  assign rows[NPP] = neg_row;

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import booth_mult_pkg::*;
#(
  parameter int W = 36,
  parameter int N = 10
) (
  input  logic [W-1:0] rows [N],
  output logic [W-1:0] sum_row,
  output logic [W-1:0] carry_row
);
  function automatic int rows_at(input int lvl);
    int n;
    n = N;
    for (int k = 0; k < lvl; k++) n = rows_after_layer(n);
    return n;
  endfunction

  function automatic int layer_count();
    int n;
    int l;
    n = N;
    l = 0;
    while (n > 2) begin
      n = rows_after_layer(n);
      l++;
    end
    return l;
  endfunction

  localparam int NLV = layer_count();

  logic [W-1:0] lv [NLV+1][N];

  for (genvar r = 0; r < N; r++) begin : g_in
    assign lv[0][r] = rows[r];
  end

  for (genvar l = 0; l < NLV; l++) begin : g_layer
    localparam int NIN  = rows_at(l);
    localparam int NG   = NIN / 3;
    localparam int NOUT = rows_at(l + 1);
    for (genvar g = 0; g < NG; g++) begin : g_csa
      logic [W-1:0] x, y, z;
      assign x = lv[l][3*g];
      assign y = lv[l][3*g+1];
      assign z = lv[l][3*g+2];
      assign lv[l+1][2*g]   = x ^ y ^ z;
      assign lv[l+1][2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
    end
    for (genvar k = 0; k < NIN - 3*NG; k++) begin : g_pass
      assign lv[l+1][2*NG+k] = lv[l][3*NG+k];
    end
    for (genvar r = NOUT; r < N; r++) begin : g_zero
      assign lv[l+1][r] = '0;
    end
  end

  assign sum_row   = lv[NLV][0];
  assign carry_row = lv[NLV][1];

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 36
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [W-1:0] half;
  logic [W-1:0] grp_g;

  // Parallel-prefix lookahead: after the loop grp_g[i] says a carry
  // leaves bit i given a zero carry into bit 0.
  always_comb begin
    logic [W-1:0] gk;
    logic [W-1:0] pk;
    gk = x & y;
    pk = x ^ y;
    for (int d = 1; d < W; d = d * 2) begin
      for (int i = W - 1; i >= d; i--) begin
        gk[i] = gk[i] | (pk[i] & gk[i-d]);
        pk[i] = pk[i] & pk[i-d];
      end
    end
    grp_g = gk;
  end

  assign half = x ^ y;
  assign s    = half ^ {grp_g[W-2:0], 1'b0};

endmodule

// File: rtl/booth_mult_tile.sv
module booth_mult_tile
  import booth_mult_pkg::*;
#(
  parameter int OP_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              cfg_unsigned,
  input  logic              cfg_sync,
  input  logic              cfg_pipe,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [2*OP_W-1:0] p
);
  // OP_W must be even and at least 4.
  localparam int PW    = 2 * OP_W;
  localparam int NPP   = OP_W / 2;
  localparam int NROWS = NPP + 1;

  timing_t       tm_sel;
  logic [OP_W-1:0] a_x, b_x;
  logic [PW-1:0] pp_rows [NROWS];
  logic [PW-1:0] tree_sum, tree_carry;
  logic [PW-1:0] st_sum, st_carry;
  logic [PW-1:0] add_x, add_y, add_out;
  logic [PW-1:0] out_q;
  logic          reg_load;

  assign tm_sel   = timing_select(cfg_sync, cfg_pipe);
  assign reg_load = ce && !rst;

  // Narrow unsigned operands become non-negative full-width values.
  assign a_x = cfg_unsigned ? {1'b0, a[OP_W-2:0]} : a;
  assign b_x = cfg_unsigned ? {1'b0, b[OP_W-2:0]} : b;

  booth_ppgen #(.OP_W(OP_W)) u_ppgen (
    .a_x  (a_x),
    .b_x  (b_x),
    .rows (pp_rows)
  );

  csa_tree #(.W(PW), .N(NROWS)) u_tree (
    .rows      (pp_rows),
    .sum_row   (tree_sum),
    .carry_row (tree_carry)
  );

  // Stage one bank: after reduction.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_sum   <= '0;
      st_carry <= '0;
    end else if (ce) begin
      st_sum   <= tree_sum;
      st_carry <= tree_carry;
    end
  end

  assign add_x = (tm_sel == TM_PIPE) ? st_sum   : tree_sum;
  assign add_y = (tm_sel == TM_PIPE) ? st_carry : tree_carry;

  cla_adder #(.W(PW)) u_cla (
    .x (add_x),
    .y (add_y),
    .s (add_out)
  );

  // Stage two bank / output register.
  always_ff @(posedge clk) begin
    if (rst)     out_q <= '0;
    else if (ce) out_q <= add_out;
  end

  assign p = (tm_sel == TM_COMB) ? add_out : out_q;

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk
  import booth_mult_pkg::*;
#(
  parameter int OP_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              cfg_unsigned,
  input logic [OP_W-1:0]   a,
  input logic [OP_W-1:0]   b,
  input logic [2*OP_W-1:0] p,
  input timing_t           tm_sel
);
  localparam int PW = 2 * OP_W;

  function automatic logic [PW-1:0] ref_prod(input logic [OP_W-1:0] x,
                                             input logic [OP_W-1:0] y,
                                             input logic u);
    logic signed [PW-1:0] xe, ye;
    xe = u ? $signed({{(OP_W+1){1'b0}}, x[OP_W-2:0]}) : $signed({{OP_W{x[OP_W-1]}}, x});
    ye = u ? $signed({{(OP_W+1){1'b0}}, y[OP_W-2:0]}) : $signed({{OP_W{y[OP_W-1]}}, y});
    return xe * ye;
  endfunction

  // R1, R3: combinational product matches the reference
  a_r3_comb_product: assert property (@(posedge clk) disable iff (rst)
    (tm_sel == TM_COMB) |-> (p == ref_prod(a, b, cfg_unsigned)));

  a_r2_unsigned_range: assert property (@(posedge clk) disable iff (rst)
    (tm_sel == TM_COMB && cfg_unsigned) |-> (p[PW-1:PW-2] == 2'b00));

  a_r4_reg_latency: assert property (@(posedge clk) disable iff (rst)
    (ce && tm_sel == TM_REG) |=>
      (tm_sel != TM_REG || p == ref_prod($past(a), $past(b), $past(cfg_unsigned))));

  a_r5_pipe_latency: assert property (@(posedge clk) disable iff (rst)
    (ce && tm_sel == TM_PIPE) ##1 (ce && tm_sel == TM_PIPE) |=>
      (tm_sel != TM_PIPE ||
       p == ref_prod($past(a, 2), $past(b, 2), $past(cfg_unsigned, 2))));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!ce && tm_sel != TM_COMB) |=> (tm_sel == TM_COMB || $stable(p)));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (tm_sel == TM_COMB || p == '0));

endmodule

bind booth_mult_tile booth_mult_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/booth_mult_tile_bench.sv
`timescale 1ns/1ps
module booth_mult_tile_bench;
  localparam int OW = 18;
  localparam int NV = 12;

  localparam logic [OW-1:0] VA [NV] = '{18'h00003, 18'h3FFFD, 18'h20000, 18'h1FFFF,
                                        18'h20000, 18'h3FFFF, 18'h1FFFF, 18'h2AAAA,
                                        18'h2AAAA, 18'h3FFFF, 18'h12345, 18'h00000};
  localparam logic [OW-1:0] VB [NV] = '{18'h00005, 18'h00007, 18'h20000, 18'h1FFFF,
                                        18'h1FFFF, 18'h3FFFF, 18'h00002, 18'h15555,
                                        18'h35555, 18'h3FFFF, 18'h2F0F0, 18'h3ABCD};
  localparam logic VM [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                               1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b1;
  logic cfg_unsigned = 1'b0;
  logic cfg_sync = 1'b1;
  logic cfg_pipe = 1'b0;
  logic [OW-1:0] a = '0;
  logic [OW-1:0] b = '0;
  logic [2*OW-1:0] p;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  booth_mult_tile #(.OP_W(OW)) u_booth_mult_tile (
    .clk(clk), .rst(rst), .ce(ce), .cfg_unsigned(cfg_unsigned),
    .cfg_sync(cfg_sync), .cfg_pipe(cfg_pipe), .a(a), .b(b), .p(p)
  );

  // Bench reference: plain integer multiply on 64-bit values.
  function automatic logic [2*OW-1:0] model(input logic [OW-1:0] x,
                                            input logic [OW-1:0] y, input logic u);
    longint xv, yv, pr;
    xv = u ? longint'(x[OW-2:0]) : longint'($signed(x));
    yv = u ? longint'(y[OW-2:0]) : longint'($signed(y));
    pr = xv * yv;
    return pr[2*OW-1:0];
  endfunction

  task automatic check(input string tag, input logic [2*OW-1:0] got, input logic [2*OW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input int k);
    a = VA[k];
    b = VB[k];
    cfg_unsigned = VM[k];
  endtask

  task automatic stream(input int lat, input string tag);
    for (int k = 0; k < NV + lat; k++) begin
      @(negedge clk);
      if (k >= lat) check(tag, p, model(VA[k-lat], VB[k-lat], VM[k-lat]));
      if (k < NV) drive(k);
    end
  endtask

  task automatic comb_case(input logic [OW-1:0] x, input logic [OW-1:0] y, input logic u,
                           input logic [2*OW-1:0] exp, input string tag);
    @(negedge clk);
    a = x; b = y; cfg_unsigned = u;
    #1 check(tag, p, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset state", p, '0);
    rst = 1'b0;

    // R1 R2 R3: combinational timing over the vector table
    cfg_sync = 1'b0; cfg_pipe = 1'b0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(k);
      #1 check(VM[k] ? "R2 unsigned comb" : "R1 signed comb", p, model(VA[k], VB[k], VM[k]));
    end

    // R4: registered timing, one new vector per cycle
    cfg_sync = 1'b1;
    stream(1, "R4 registered latency");

    // R5: pipelined timing, cfg_sync low to show it is overridden
    cfg_sync = 1'b0; cfg_pipe = 1'b1;
    stream(2, "R5 pipelined latency");

    // R8: extreme operands with literal expectations
    cfg_pipe = 1'b0;
    comb_case(18'h20000, 18'h20000, 1'b0, 36'h400000000, "R8 min x min");
    comb_case(18'h1FFFF, 18'h1FFFF, 1'b0, 36'h3FFFC0001, "R8 max x max");
    comb_case(18'h20000, 18'h1FFFF, 1'b0, 36'hC00020000, "R8 min x max");
    comb_case(18'h3FFFF, 18'h3FFFF, 1'b1, 36'h3FFFC0001, "R8 unsigned max");
    comb_case(18'h3FFFF, 18'h3FFFF, 1'b0, 36'h000000001, "R1 minus one squared");
    comb_case(18'h20001, 18'h00003, 1'b1, 36'h000000003, "R2 bit 17 ignored");

    // R6: clock enable hold in registered timing
    cfg_sync = 1'b1;
    @(negedge clk);
    a = 18'h00011; b = 18'h00013; cfg_unsigned = 1'b0;
    @(negedge clk);
    check("R6 load before hold", p, 36'd323);
    ce = 1'b0; a = 18'h00100; b = 18'h00100;
    repeat (2) @(negedge clk);
    check("R6 hold registered", p, 36'd323);
    ce = 1'b1;
    @(negedge clk);
    check("R6 resume", p, 36'h000010000);

    // R6: hold in pipelined timing
    cfg_pipe = 1'b1;
    a = 18'h00007; b = 18'h00009;
    repeat (2) @(negedge clk);
    check("R6 pipe load", p, 36'd63);
    ce = 1'b0; a = 18'h00002; b = 18'h00002;
    repeat (3) @(negedge clk);
    check("R6 hold pipelined", p, 36'd63);

    // R7: reset overrides a low enable
    rst = 1'b1;
    @(negedge clk);
    check("R7 pipe reset with ce low", p, '0);
    cfg_pipe = 1'b0;
    rst = 1'b0; ce = 1'b1;
    @(negedge clk);
    check("R7 reg reload after reset", p, 36'd4);
    rst = 1'b1; ce = 1'b0;
    @(negedge clk);
    check("R7 reg reset with ce low", p, '0);
    rst = 1'b0; ce = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule